// File: doc/BRIEF.md
# 66-bit Block Boundary Lock

This block finds the word boundary in a deserialized stream of 66-bit blocks. Each block carries a two-bit sync header that marks it as data or control. Before lock, the far end transmits only control blocks. The block therefore hunts for the bit offset at which every header reads as control. Each time a header does not match, it asks the deserializer to shift by one bit. It then ignores a fixed number of blocks while the shifted stream settles.

After an unbroken run of control headers, the block declares lock and raises a ready flag. This flag is carried in the outgoing link status, so the peer knows it may start sending user data. While locked, data and control headers are both accepted. The two impossible header codes are counted over a sliding block window. Too many of them within one window drops lock and restarts the hunt.

Top module: `align_lock_fsm`

## Requirements
- R1: A synchronous active-low reset forces `ready_o` low and `slip_o` low, and restarts the search with an empty run count.
- R2: While searching, a valid block whose header is not the control code 2'b10 (so 2'b01, 2'b00 or 2'b11) drives `slip_o` high for exactly one cycle. That cycle is the one following the clock edge that sampled the block.
- R3: After a slip request, the next `SLIP_WAIT` valid blocks (default 32) are ignored. They cause no slip and are not counted toward lock. Header checking resumes with the block after them.
- R4: Lock is declared after `LOCK_RUN` consecutive valid blocks (default 128) with header 2'b10. `ready_o` rises in the cycle after the edge that sampled the last block of the run.
- R5: Any non-control header during the search empties the run count, so a full new run of `LOCK_RUN` control blocks is needed afterwards.
- R6: While locked, `ready_o` stays high on every cycle, and `slip_o` stays low.
- R7: While locked, headers 2'b01 (data) and 2'b10 (control) are both legal. Neither counts toward loss of lock.
- R8: While locked, the `BAD_LIMIT`-th illegal header (2'b00 or 2'b11) within one window drops lock. The default limit is 16. `ready_o` falls in the next cycle, and the search restarts from an empty run count.
- R9: The window spans `WIN_LEN` valid blocks (default 64) and starts when lock is gained. At the end of each window the illegal count is cleared, so illegal headers spread across two windows do not add together.
- R10: Cycles with `hdr_vld_i` low change no state and raise no slip request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hdr_i | input | 2 | Sync header of the current candidate block |
| hdr_vld_i | input | 1 | Qualifies `hdr_i` for this cycle |
| slip_o | output | 1 | One-cycle request to shift the deserializer by one bit |
| ready_o | output | 1 | Lock achieved; sent to the peer in the link status |

## Verification
The bench builds the block with its default parameters: a run of 128, a wait of 32, a window of 64 and a limit of 16. At these sizes every boundary takes only a few hundred blocks to reach. This covers a run broken one block short of lock, the wait expiring on its exact count, 15 illegal headers in each of two adjacent windows, and the 16th illegal header in a single window. Random header streams with gaps in the valid strobe then drive the search, wait and locked states many times each. A reference model in the bench tracks every block.

// File: rtl/align_pkg.sv
// Package align_pkg
// Shared types and header codes for the 66-bit block alignment logic.
// Assumes a two-bit sync header where 2'b01 is data and 2'b10 is control.
package align_pkg;

    typedef enum logic [1:0] {
        ST_SEARCH    = 2'd0,
        ST_SLIP_WAIT = 2'd1,
        ST_LOCKED    = 2'd2
    } align_state_t;

    localparam logic [1:0] HDR_DATA = 2'b01;
    localparam logic [1:0] HDR_CTRL = 2'b10;

    // True for the two header codes a correctly aligned stream can carry.
    function automatic logic hdr_legal(input logic [1:0] hdr);
        return (hdr == HDR_DATA) || (hdr == HDR_CTRL);
    endfunction

endpackage

// File: rtl/align_hdr_class.sv
// Module align_hdr_class
// Sorts one candidate header into the classes the lock FSM acts on.
// All outputs are qualified by the valid strobe. The block is purely combinational.
module align_hdr_class
    import align_pkg::*;
(
    input  logic [1:0] hdr_i,
    input  logic       vld_i,
    output logic       ctrl_o,
    output logic       miss_o,
    output logic       illegal_o
);

    // Classify the header for this cycle.
    always_comb begin
        ctrl_o    = vld_i && (hdr_i == HDR_CTRL);
        miss_o    = vld_i && (hdr_i != HDR_CTRL);
        illegal_o = vld_i && !hdr_legal(hdr_i);
    end

endmodule

// File: rtl/align_count.sv
// Module align_count
// Up-counter that reports when it holds LIMIT-1, i.e. when the next
// increment completes LIMIT events. A clear overrides an increment.
// The owner must clear the counter before it would pass LIMIT-1.
module align_count #(
    parameter int unsigned LIMIT = 128,
    localparam int unsigned CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic at_last_o
);

    logic [CW-1:0] cnt_q;

    // Count events, with clear taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Flag the final count before the limit.
    always_comb begin
        at_last_o = (cnt_q == CW'(LIMIT - 1));
    end

endmodule

// File: rtl/align_lock_fsm.sv
// Module align_lock_fsm
// Word boundary search and lock supervision for 66-bit blocks.
// Assumes the peer sends only control blocks until it sees ready,
// and that the deserializer applies a slip within SLIP_WAIT blocks.
// Outputs are registered.
module align_lock_fsm
    import align_pkg::*;
#(
    parameter int unsigned LOCK_RUN  = 128,
    parameter int unsigned SLIP_WAIT = 32,
    parameter int unsigned WIN_LEN   = 64,
    parameter int unsigned BAD_LIMIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] hdr_i,
    input  logic       hdr_vld_i,
    output logic       slip_o,
    output logic       ready_o
);

    align_state_t state_q, state_d;
    logic blk_ctrl, blk_miss, blk_illegal;
    logic run_clr, run_inc, run_last;
    logic wait_clr, wait_inc, wait_last;
    logic win_clr, win_inc, win_last;
    logic bad_clr, bad_inc, bad_last;
    logic slip_d;

    align_hdr_class u_class (
        .hdr_i    (hdr_i),
        .vld_i    (hdr_vld_i),
        .ctrl_o   (blk_ctrl),
        .miss_o   (blk_miss),
        .illegal_o(blk_illegal)
    );

    align_count #(.LIMIT(LOCK_RUN)) u_run (
        .clk(clk), .rst_n(rst_n), .clr_i(run_clr), .inc_i(run_inc), .at_last_o(run_last)
    );

    align_count #(.LIMIT(SLIP_WAIT)) u_wait (
        .clk(clk), .rst_n(rst_n), .clr_i(wait_clr), .inc_i(wait_inc), .at_last_o(wait_last)
    );

    align_count #(.LIMIT(WIN_LEN)) u_win (
        .clk(clk), .rst_n(rst_n), .clr_i(win_clr), .inc_i(win_inc), .at_last_o(win_last)
    );

    align_count #(.LIMIT(BAD_LIMIT)) u_bad (
        .clk(clk), .rst_n(rst_n), .clr_i(bad_clr), .inc_i(bad_inc), .at_last_o(bad_last)
    );

    // Counter controls: each counter runs only in its own state.
    always_comb begin
        run_inc  = (state_q == ST_SEARCH) && blk_ctrl;
        run_clr  = (state_q != ST_SEARCH) || blk_miss;
        wait_inc = (state_q == ST_SLIP_WAIT) && hdr_vld_i;
        wait_clr = (state_q != ST_SLIP_WAIT);
        win_inc  = (state_q == ST_LOCKED) && hdr_vld_i;
        win_clr  = (state_q != ST_LOCKED) || (hdr_vld_i && win_last);
        bad_inc  = (state_q == ST_LOCKED) && blk_illegal;
        bad_clr  = win_clr;
    end

    // Next state and slip request.
    always_comb begin
        state_d = state_q;
        slip_d  = 1'b0;
        unique case (state_q)
            ST_SEARCH: begin
                if (blk_ctrl && run_last) begin
                    state_d = ST_LOCKED;
                end else if (blk_miss) begin
                    state_d = ST_SLIP_WAIT;
                    slip_d  = 1'b1;
                end
            end
            ST_SLIP_WAIT: begin
                if (hdr_vld_i && wait_last) begin
                    state_d = ST_SEARCH;
                end
            end
            ST_LOCKED: begin
                if (blk_illegal && bad_last) begin
                    state_d = ST_SEARCH;
                end
            end
            default: state_d = ST_SEARCH;
        endcase
    end

    // State and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SEARCH;
            slip_o  <= 1'b0;
            ready_o <= 1'b0;
        end else begin
            state_q <= state_d;
            slip_o  <= slip_d;
            ready_o <= (state_d == ST_LOCKED);
        end
    end

endmodule

// File: rtl/align_lock_fsm_chk.sv
// Module align_lock_fsm_chk
// Port-level properties of align_lock_fsm, attached by bind.
module align_lock_fsm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] hdr_i,
    input logic       hdr_vld_i,
    input logic       slip_o,
    input logic       ready_o
);

    // R2: a slip request lasts one cycle.
    p_slip_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        slip_o |=> !slip_o);

    // R2: a slip follows a sampled non-control header while unlocked.
    p_slip_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        slip_o |-> $past(hdr_vld_i && hdr_i != 2'b10 && !ready_o));

    // R6: no slip while locked.
    p_no_slip_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> !slip_o);

    // R4: lock is gained only on a control header.
    p_ready_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ready_o) && $past(rst_n)) |-> $past(hdr_vld_i && hdr_i == 2'b10));

    // R8: lock is lost only on an illegal header.
    p_ready_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ready_o) && $past(rst_n)) |-> $past(hdr_vld_i && (hdr_i == 2'b00 || hdr_i == 2'b11)));

    // R10: an idle cycle changes nothing visible.
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_vld_i |=> ($stable(ready_o) && !slip_o));

endmodule

bind align_lock_fsm align_lock_fsm_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hdr_i    (hdr_i),
    .hdr_vld_i(hdr_vld_i),
    .slip_o   (slip_o),
    .ready_o  (ready_o)
);

// File: tb/align_lock_fsm_bench.sv
`timescale 1ns/1ps
module align_lock_fsm_bench;

    localparam int LOCK_RUN  = 128;
    localparam int SLIP_WAIT = 32;
    localparam int WIN_LEN   = 64;
    localparam int BAD_LIMIT = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] hdr = 2'b10;
    logic       vld = 1'b0;
    logic       slip_o, ready_o;

    int checks = 0;
    int errors = 0;

    // Reference model state: 0 search, 1 wait, 2 locked.
    int m_st = 0, m_run = 0, m_wait = 0, m_win = 0, m_bad = 0;
    logic m_slip = 1'b0, m_ready = 1'b0;

    always #10 clk = ~clk;

    align_lock_fsm #(
        .LOCK_RUN(LOCK_RUN), .SLIP_WAIT(SLIP_WAIT),
        .WIN_LEN(WIN_LEN), .BAD_LIMIT(BAD_LIMIT)
    ) u_align_lock_fsm (
        .clk(clk), .rst_n(rst_n), .hdr_i(hdr), .hdr_vld_i(vld),
        .slip_o(slip_o), .ready_o(ready_o)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // Reference model: advance by one block as the requirements describe.
    task automatic model_step(input logic [1:0] h, input logic v);
        m_slip = 1'b0;
        if (v) begin
            case (m_st)
                0: if (h == 2'b10) begin
                       m_run++;
                       if (m_run == LOCK_RUN) begin m_st = 2; m_win = 0; m_bad = 0; end
                   end else begin
                       m_slip = 1'b1; m_run = 0; m_st = 1; m_wait = 0;
                   end
                1: begin
                       m_wait++;
                       if (m_wait == SLIP_WAIT) begin m_st = 0; m_run = 0; end
                   end
                default: begin
                       m_win++;
                       if (h == 2'b00 || h == 2'b11) m_bad++;
                       if (m_bad == BAD_LIMIT) begin m_st = 0; m_run = 0; end
                       else if (m_win == WIN_LEN) begin m_win = 0; m_bad = 0; end
                   end
            endcase
        end
        m_ready = (m_st == 2);
    endtask

    // Drive one block at a falling edge and compare after the rising edge.
    task automatic blk(input logic [1:0] h, input logic v, input string req);
        hdr = h; vld = v;
        @(negedge clk);
        model_step(h, v);
        chk(req, "slip_o", slip_o, m_slip);
        chk(req, "ready_o", ready_o, m_ready);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; vld = 1'b0;
        repeat (3) @(negedge clk);
        m_st = 0; m_run = 0; m_wait = 0; m_slip = 1'b0; m_ready = 1'b0;
        chk("R1", "ready_o after reset", ready_o, 1'b0);
        chk("R1", "slip_o after reset", slip_o, 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        do_reset();

        // R2: a data header while searching requests one slip.
        blk(2'b01, 1'b1, "R2");
        chk("R2", "slip after data header", slip_o, 1'b1);
        blk(2'b10, 1'b0, "R10");
        chk("R2", "slip one cycle only", slip_o, 1'b0);

        // R3: illegal headers during the wait are ignored.
        for (int i = 0; i < SLIP_WAIT; i++) blk(2'b00, 1'b1, "R3");
        chk("R3", "no slip during wait", slip_o, 1'b0);
        blk(2'b11, 1'b1, "R3");
        chk("R3", "slip resumes after wait", slip_o, 1'b1);
        for (int i = 0; i < SLIP_WAIT; i++) blk(2'b10, 1'b1, "R3");

        // R5: a run broken one block short of lock starts over.
        for (int i = 0; i < LOCK_RUN - 1; i++) blk(2'b10, 1'b1, "R5");
        chk("R5", "not locked one short", ready_o, 1'b0);
        blk(2'b01, 1'b1, "R5");
        chk("R5", "break slips", slip_o, 1'b1);
        for (int i = 0; i < SLIP_WAIT; i++) blk(2'b10, 1'b1, "R3");
        for (int i = 0; i < LOCK_RUN - 1; i++) blk(2'b10, i % 5 != 0 || i == 0, "R4");
        for (int i = 0; i < LOCK_RUN; i++) if (!m_ready && m_run < LOCK_RUN - 1) blk(2'b10, 1'b1, "R4");
        chk("R4", "still unlocked before last block", ready_o, 1'b0);
        blk(2'b10, 1'b1, "R4");
        chk("R4", "locked after full run", ready_o, 1'b1);

        // R7 R6: data and control headers keep lock.
        for (int i = 0; i < 40; i++) blk(i % 3 == 0 ? 2'b10 : 2'b01, 1'b1, "R7");
        for (int i = 0; i < WIN_LEN - 40; i++) blk(2'b01, 1'b1, "R6");
        chk("R7", "legal headers hold lock", ready_o, 1'b1);

        // R9: one below the limit in each of two windows keeps lock.
        for (int w = 0; w < 2; w++) begin
            for (int i = 0; i < WIN_LEN; i++) blk(i < BAD_LIMIT - 1 ? 2'b11 : 2'b01, 1'b1, "R9");
        end
        chk("R9", "window resets illegal count", ready_o, 1'b1);

        // R8: reaching the limit inside one window drops lock.
        for (int i = 0; i < BAD_LIMIT - 1; i++) blk(2'b00, 1'b1, "R8");
        chk("R8", "locked one below limit", ready_o, 1'b1);
        blk(2'b00, 1'b1, "R8");
        chk("R8", "lock dropped at limit", ready_o, 1'b0);
        for (int i = 0; i < LOCK_RUN - 1; i++) blk(2'b10, 1'b1, "R8");
        chk("R8", "search restarted from zero", ready_o, 1'b0);
        blk(2'b10, 1'b1, "R8");
        chk("R8", "relocked", ready_o, 1'b1);

        // R1: reset while locked.
        do_reset();

        // Random headers and valid gaps, checked against the model.
        for (int i = 0; i < 6000; i++) begin
            int r;
            logic [1:0] h;
            r = int'($urandom_range(99));
            if (m_st == 2) h = (r < 20) ? 2'($urandom_range(1) * 3) : (r < 60 ? 2'b01 : 2'b10);
            else           h = (r < 97) ? 2'b10 : 2'($urandom_range(3));
            blk(h, ($urandom_range(7) != 0), "R10");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule